// File: doc/BRIEF.md
# Pin Event Flag Aggregator

This block keeps one status flag per pin for a 32-pin port and combines those flags into a small set of outputs. A 4-bit code selects each pin's role. A pin can be unused, a DMA source that fires on an edge, an interrupt source that fires on a level or an edge, or a trigger source. Edges are found by comparing the synchronized pin level with the level registered on the previous clock.

The flags of DMA pins drive one shared DMA request, and the flags of interrupt pins drive one interrupt line. A wake-up output rises, with no clock in its path, when an interrupt pin detects its event while the device is in stop mode. Software clears flags by writing ones. A DMA-complete strobe clears the flags of every DMA pin, and this is what drops the shared request. A separate trigger output is a purely combinational OR over the trigger pins. Each trigger pin is read from its filtered level when its filter is on and from its raw level when the filter is off.

Top module: `pin_evt_agg`

## Requirements
- R1: `dma_req_o` is high exactly when some pin whose current code is 1, 2 or 3 (DMA) has its flag set.
- R2: With `dma_done_i` high at a clock edge, every pin whose code is 1..3 has its flag clear after that edge, unless that pin has an event in the same cycle.
- R3: An event is detected with `prev` equal to the `pin_sync_i` bit registered on the previous clock (0 after reset). Code 1 and code 9 fire on rise (`cur & ~prev`). Code 2 and code 10 fire on fall. Code 3 and code 11 fire on either edge. Code 8 fires while `cur` is 0, and code 12 fires while `cur` is 1. An event sets the pin's flag at the next clock edge.
- R4: Codes 0, 4 to 7, 13, 14 and 15 never set a flag.
- R5: While `stop_i` is high, events on DMA pins (codes 1..3) are ignored, but interrupt pins (codes 8..12) still set their flags. `wake_o` is high in the same cycle, combinationally, when `stop_i` is high and some interrupt pin has an event. `wake_o` is low whenever `stop_i` is low.
- R6: `irq_o` is high exactly when some pin whose current code is 8..12 has its flag set.
- R7: `trig_o` is high when some pin with code 13 reads 1 or some pin with code 14 reads 0. It follows its inputs combinationally, in the same cycle.
- R8: A trigger pin reads `pin_filt_i` when its `filt_en_i` bit is 1, and `pin_raw_i` otherwise.
- R9: A 1 in bit i of `w1c_i` at a clock edge clears flag i.
- R10: When a pin has an event in the same cycle as a clear by `w1c_i` or `dma_done_i`, its flag is set after the edge.
- R11: While `rst_n` is low, `flag_o`, `dma_req_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Device is in stop mode |
| pin_sync_i | input | 32 | Synchronized pin levels used for event detection |
| pin_raw_i | input | 32 | Raw pin levels for the trigger |
| pin_filt_i | input | 32 | Filtered pin levels for the trigger |
| filt_en_i | input | 32 | Per-pin filter enable (selects the trigger source) |
| cfg_i | input | 128 | 4-bit mode code per pin, pin i in bits [4i+3:4i] |
| w1c_i | input | 32 | Write-one-to-clear strobe per flag |
| dma_done_i | input | 1 | DMA transfer complete strobe |
| flag_o | output | 32 | Per-pin status flags |
| dma_req_o | output | 1 | Combined DMA request |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | Asynchronous wake-up from stop mode |
| trig_o | output | 1 | Combined peripheral trigger |

## Verification
Flags are due one clock after the cycle that holds their event or clear. The bench therefore checks `flag_o` at the falling edge that follows each rising edge, before it drives new inputs. `wake_o` and `trig_o` have no register in their path, so they are checked a short delay after the inputs change in the same cycle. `dma_req_o` and `irq_o` are checked in that same window against the registered flags and the current codes. A bench model steps once per rising edge from the same inputs, so every expected value lines up with the cycle in which the design produces it.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int CFG_W = 4;

  localparam logic [CFG_W-1:0] M_DMA_RISE  = 4'd1;
  localparam logic [CFG_W-1:0] M_DMA_FALL  = 4'd2;
  localparam logic [CFG_W-1:0] M_DMA_ANY   = 4'd3;
  localparam logic [CFG_W-1:0] M_INT_LOW   = 4'd8;
  localparam logic [CFG_W-1:0] M_INT_RISE  = 4'd9;
  localparam logic [CFG_W-1:0] M_INT_FALL  = 4'd10;
  localparam logic [CFG_W-1:0] M_INT_ANY   = 4'd11;
  localparam logic [CFG_W-1:0] M_INT_HIGH  = 4'd12;
  localparam logic [CFG_W-1:0] M_TRIG_HIGH = 4'd13;
  localparam logic [CFG_W-1:0] M_TRIG_LOW  = 4'd14;

  function automatic logic mode_is_dma(logic [CFG_W-1:0] m);
    return (m >= M_DMA_RISE) && (m <= M_DMA_ANY);
  endfunction

  function automatic logic mode_is_int(logic [CFG_W-1:0] m);
    return (m >= M_INT_LOW) && (m <= M_INT_HIGH);
  endfunction

  function automatic logic mode_hit(logic [CFG_W-1:0] m, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (m)
      M_DMA_RISE, M_INT_RISE: return rise;
      M_DMA_FALL, M_INT_FALL: return fall;
      M_DMA_ANY,  M_INT_ANY:  return rise | fall;
      M_INT_LOW:              return ~cur;
      M_INT_HIGH:             return cur;
      default:                return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_i,
  input  logic [NPINS-1:0]       pin_i,
  input  logic [NPINS*CFG_W-1:0] cfg_i,
  output logic [NPINS-1:0]       evt_o,
  output logic [NPINS-1:0]       is_dma_o,
  output logic [NPINS-1:0]       is_int_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] prev_d;

  always_comb prev_d = pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [CFG_W-1:0] mode;
    logic             hit;
    always_comb begin
      mode        = cfg_i[i*CFG_W +: CFG_W];
      is_dma_o[i] = mode_is_dma(mode);
      is_int_o[i] = mode_is_int(mode);
      hit         = mode_hit(mode, pin_i[i], prev_q[i]);
      evt_o[i]    = hit & (is_int_o[i] | (is_dma_o[i] & ~stop_i));
    end
  end
endmodule

// File: rtl/pin_evt_flags.sv
module pin_evt_flags #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] flag_o
);
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] flag_d;
  logic             upd_en;

  always_comb begin
    upd_en = |(evt_i | clr_i);
    flag_d = (flag_q & ~clr_i) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= '0;
    else if (upd_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pin_evt_trig.sv
module pin_evt_trig
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]       raw_i,
  input  logic [NPINS-1:0]       filt_i,
  input  logic [NPINS-1:0]       fen_i,
  input  logic [NPINS*CFG_W-1:0] cfg_i,
  output logic                   trig_o
);
  logic [NPINS-1:0] match;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic             lvl;
    logic [CFG_W-1:0] mode;
    always_comb begin
      mode     = cfg_i[i*CFG_W +: CFG_W];
      lvl      = fen_i[i] ? filt_i[i] : raw_i[i];
      match[i] = ((mode == M_TRIG_HIGH) &  lvl) |
                 ((mode == M_TRIG_LOW)  & ~lvl);
    end
  end

  assign trig_o = |match;
endmodule

// File: rtl/pin_evt_agg.sv
module pin_evt_agg
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_i,
  input  logic [NPINS-1:0]       pin_sync_i,
  input  logic [NPINS-1:0]       pin_raw_i,
  input  logic [NPINS-1:0]       pin_filt_i,
  input  logic [NPINS-1:0]       filt_en_i,
  input  logic [NPINS*CFG_W-1:0] cfg_i,
  input  logic [NPINS-1:0]       w1c_i,
  input  logic                   dma_done_i,
  output logic [NPINS-1:0]       flag_o,
  output logic                   dma_req_o,
  output logic                   irq_o,
  output logic                   wake_o,
  output logic                   trig_o
);
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] is_dma;
  logic [NPINS-1:0] is_int;
  logic [NPINS-1:0] clr;

  pin_evt_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_i   (stop_i),
    .pin_i    (pin_sync_i),
    .cfg_i    (cfg_i),
    .evt_o    (evt),
    .is_dma_o (is_dma),
    .is_int_o (is_int)
  );

  always_comb clr = w1c_i | (is_dma & {NPINS{dma_done_i}});

  pin_evt_flags #(.NPINS(NPINS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .clr_i  (clr),
    .flag_o (flag_o)
  );

  pin_evt_trig #(.NPINS(NPINS)) u_trig (
    .raw_i  (pin_raw_i),
    .filt_i (pin_filt_i),
    .fen_i  (filt_en_i),
    .cfg_i  (cfg_i),
    .trig_o (trig_o)
  );

  always_comb begin
    dma_req_o = |(flag_o & is_dma);
    irq_o     = |(flag_o & is_int);
    wake_o    = stop_i & |(evt & is_int);
  end
endmodule

// File: rtl/pin_evt_agg_chk.sv
module pin_evt_agg_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic [NPINS-1:0] w1c_i,
  input logic             dma_done_i,
  input logic [NPINS-1:0] flag_o,
  input logic             dma_req_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic [NPINS-1:0] evt,
  input logic [NPINS-1:0] dma_mask
);
  a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(w1c_i & ~evt)) |=> ((flag_o & $past(w1c_i & ~evt)) == '0));

  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_i |=> ((flag_o & $past(dma_mask & ~evt)) == '0));

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag_o & $past(evt)) == $past(evt)));

  a_r5_wake_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |-> !wake_o);

  a_r1_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (|flag_o));

  a_r6_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flag_o));
endmodule

bind pin_evt_agg pin_evt_agg_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .w1c_i      (w1c_i),
  .dma_done_i (dma_done_i),
  .flag_o     (flag_o),
  .dma_req_o  (dma_req_o),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .evt        (evt),
  .dma_mask   (is_dma)
);

// File: tb/pin_evt_agg_bench.sv
module pin_evt_agg_bench;
  localparam int N = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           stop_i;
  logic [N-1:0]   pin_sync_i, pin_raw_i, pin_filt_i, filt_en_i, w1c_i;
  logic [N*4-1:0] cfg_i;
  logic           dma_done_i;
  logic [N-1:0]   flag_o;
  logic           dma_req_o, irq_o, wake_o, trig_o;

  int n_run  = 0;
  int n_fail = 0;

  logic [N-1:0] m_flag, m_prev;

  always #10 clk = ~clk;

  pin_evt_agg u_pin_evt_agg (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pin_sync_i(pin_sync_i),
    .pin_raw_i(pin_raw_i), .pin_filt_i(pin_filt_i), .filt_en_i(filt_en_i),
    .cfg_i(cfg_i), .w1c_i(w1c_i), .dma_done_i(dma_done_i), .flag_o(flag_o),
    .dma_req_o(dma_req_o), .irq_o(irq_o), .wake_o(wake_o), .trig_o(trig_o)
  );

  function automatic logic [3:0] code(int i);
    return cfg_i[i*4 +: 4];
  endfunction
  function automatic logic f_dma(logic [3:0] c);
    return c >= 1 && c <= 3;
  endfunction
  function automatic logic f_int(logic [3:0] c);
    return c >= 8 && c <= 12;
  endfunction
  function automatic logic f_hit(logic [3:0] c, logic cur, logic prv);
    case (c)
      4'd1, 4'd9:  return cur && !prv;
      4'd2, 4'd10: return !cur && prv;
      4'd3, 4'd11: return cur != prv;
      4'd8:        return !cur;
      4'd12:       return cur;
      default:     return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: check flags, drive (already set by caller), check comb, step model
  task automatic step();
    logic [N-1:0] ev, dm, im, clr;
    logic trg, lvl;
    #2;
    ev = '0; dm = '0; im = '0; trg = 1'b0;
    for (int i = 0; i < N; i++) begin
      dm[i] = f_dma(code(i));
      im[i] = f_int(code(i));
      ev[i] = f_hit(code(i), pin_sync_i[i], m_prev[i]) && (im[i] || (dm[i] && !stop_i));
      lvl = filt_en_i[i] ? pin_filt_i[i] : pin_raw_i[i];
      if ((code(i) == 4'd13 && lvl) || (code(i) == 4'd14 && !lvl)) trg = 1'b1;
    end
    chk("R1 dma_req_o", N'(dma_req_o), N'(|(m_flag & dm)));
    chk("R6 irq_o", N'(irq_o), N'(|(m_flag & im)));
    chk("R5 wake_o", N'(wake_o), N'(stop_i && |(ev & im)));
    chk("R7 R8 trig_o", N'(trig_o), N'(trg));
    clr = w1c_i | (dma_done_i ? dm : '0);
    m_flag = (m_flag & ~clr) | ev;
    m_prev = pin_sync_i;
    @(negedge clk);
    chk("R2 R3 R4 R5 R9 R10 flag_o", flag_o, m_flag);
  endtask

  task automatic quiet();
    w1c_i = '0; dma_done_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; stop_i = 1'b0; pin_sync_i = '0; pin_raw_i = '0;
    pin_filt_i = '0; filt_en_i = '0; w1c_i = '0; dma_done_i = 1'b0;
    cfg_i = {N{4'd12}};
    pin_sync_i = '1;
    m_flag = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    chk("R11 flag_o", flag_o, '0);
    chk("R11 dma_req_o", N'(dma_req_o), '0);
    chk("R11 irq_o", N'(irq_o), '0);
    pin_sync_i = '0; cfg_i = {N{4'd9}};
    rst_n = 1'b1;
    step();
    // R3: rising edge on every interrupt-rise pin
    pin_sync_i = '1; step();
    // R9: clear all flags, pins steady
    w1c_i = '1; step(); quiet();
    // R10 / R1 / R2: DMA rise on pin0 with simultaneous clears
    cfg_i = '0; cfg_i[3:0] = 4'd1;
    pin_sync_i = '0; step();
    pin_sync_i[0] = 1'b1; w1c_i[0] = 1'b1; dma_done_i = 1'b1; step(); quiet();
    step();
    dma_done_i = 1'b1; step(); quiet();
    // R5: stop masks DMA edges, interrupt level-high still flags and wakes
    stop_i = 1'b1; cfg_i[7:4] = 4'd12;
    pin_sync_i = '0; step();
    pin_sync_i[0] = 1'b1; pin_sync_i[1] = 1'b1; step();
    stop_i = 1'b0; w1c_i = '1; pin_sync_i = '0; step(); quiet();
    // R4: unused and trigger codes never flag
    cfg_i = {8{4'd15, 4'd14, 4'd13, 4'd7, 4'd6, 4'd5, 4'd4, 4'd0}};
    pin_sync_i = '1; step(); pin_sync_i = '0; step();
    // R7 R8: trigger source selection
    pin_raw_i = '1; pin_filt_i = '0; filt_en_i = '0; step();
    filt_en_i = '1; step();
    pin_raw_i = '0; filt_en_i = '0; step();
    // random phase
    for (int k = 0; k < 6000; k++) begin
      if (k % 300 == 0)
        for (int i = 0; i < N; i++) cfg_i[i*4 +: 4] = 4'($urandom % 16);
      if (k % 50 == 0) stop_i = ($urandom % 4) == 0;
      pin_sync_i = pin_sync_i ^ ($urandom & $urandom);
      pin_raw_i  = $urandom;
      pin_filt_i = $urandom;
      filt_en_i  = $urandom;
      w1c_i      = $urandom & $urandom & $urandom;
      dma_done_i = ($urandom % 12) == 0;
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule